// File: doc/BRIEF.md
# Frequency Acquisition Search Controller

This block steers the digital tuning code of a controlled oscillator until the oscillator runs close to a target rate. It then hands control to a fine phase-tracking loop. A lock detector supplies signed frequency-error measurements and a loss-of-lock flag. While it is searching, the controller raises the code only when the oscillator is slow. The code moves in large increments while the error is large, and the increments get smaller as the error closes. Once the error falls inside the lock window, the code is frozen and the handoff enable goes high.

After lock, the controller keeps watching the measurements. An error beyond the wider release window starts a fresh search from code zero. So does the loss-of-lock flag at any time. The search never moves downward and never wraps: at the top of the range the code saturates.

Measurements arrive on a valid/ready stream. `meas_ready` is held high in every state, so the controller never applies back-pressure. A measurement transfers on every clock in which `meas_valid` is high. The source does not need to hold a word: each word with `meas_valid` high is consumed in that cycle. `lol` and `fine_en` are plain level signals.

Top module: `freq_search_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, `tune_code` is 0 and `fine_en` is 0 after the next clock edge, and the controller is searching.
- R2: When `lol` is high at a clock edge, `tune_code` becomes 0 and `fine_en` becomes 0 after that edge, whatever the measurement stream carries in that cycle.
- R3: A measurement is used only in a cycle with `meas_valid` high (`meas_ready` is always 1). With `meas_valid` low and `lol` low, `tune_code` and `fine_en` keep their values.
- R4: `meas_err` is two's complement in ppm; a positive value means the oscillator is below target. While searching, a measurement with `meas_err` > 250 adds a step to the code after that edge. The step is 256 when the magnitude is at least 64000, 64 when it is at least 16000, 16 when it is at least 4000, 4 when it is at least 1000, and 1 otherwise.
- R5: While searching, a measurement with `meas_err` < -250 leaves `tune_code` unchanged and the controller keeps searching.
- R6: While searching, a measurement with magnitude at most 250 sets `fine_en` to 1 after that edge and leaves `tune_code` unchanged.
- R7: While locked, a measurement with magnitude at most 1000 leaves `tune_code` and `fine_en` unchanged.
- R8: While locked, a measurement with magnitude above 1000 sets `tune_code` to 0 and `fine_en` to 0 after that edge, and a new search begins.
- R9: An increment that would pass 4095 leaves the code at 4095. The code never wraps, and searching continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lol | input | 1 | Loss-of-lock flag from the lock detector; restarts the search |
| meas_valid | input | 1 | Measurement word present |
| meas_ready | output | 1 | Measurement accepted; constant 1 |
| meas_err | input | 20 | Signed frequency error in ppm, positive when the oscillator is slow |
| tune_code | output | 12 | Oscillator tuning code |
| fine_en | output | 1 | Handoff enable for the fine phase loop |

## Verification
The bench builds the block with its default parameters: a 12-bit code, a 20-bit error, lock at 250 ppm, release above 1000 ppm, and step thresholds of 64000/16000/4000/1000 ppm. With these values, a measurement sequence drawn directly from the step table lands exactly on every threshold edge, including 250 against 251 and 1000 against 1001. A closed-loop oscillator model at 50 ppm per code then brings two more cases within a few thousand cycles: convergence from zero to a mid-range target, and saturation at 4095 against a target above the range.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic {ST_SEARCH = 1'b0, ST_LOCKED = 1'b1} fsc_state_e;
  localparam int unsigned N_STEP_LEVELS = 5;
endpackage

// File: rtl/fsc_err_classify.sv
module fsc_err_classify #(
  parameter int unsigned ERR_W      = 20,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned LOCK_PPM   = 250,
  parameter int unsigned UNLOCK_PPM = 1000,
  parameter int unsigned STEP_SHIFT = 2,
  parameter int unsigned STEP_TH [fsc_pkg::N_STEP_LEVELS-1] = '{64000, 16000, 4000, 1000}
) (
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    slow_o,
  output logic                    in_lock_o,
  output logic                    out_lock_o,
  output logic [CODE_W-1:0]       step_o
);
  localparam int unsigned MAG_W = ERR_W + 1;
  localparam int unsigned NLEV  = fsc_pkg::N_STEP_LEVELS;

  logic [MAG_W-1:0] mag;

  always_comb begin
    if (err_i[ERR_W-1]) mag = MAG_W'(-$signed({err_i[ERR_W-1], err_i}));
    else                mag = MAG_W'({1'b0, err_i});
  end

  assign slow_o     = !err_i[ERR_W-1] && (err_i != '0);
  assign in_lock_o  = (mag <= MAG_W'(LOCK_PPM));
  assign out_lock_o = (mag >  MAG_W'(UNLOCK_PPM));

  // first threshold met (largest first) selects the coarsest step
  always_comb begin
    step_o = CODE_W'(1);
    for (int k = NLEV - 2; k >= 0; k--) begin
      if (mag >= MAG_W'(STEP_TH[k]))
        step_o = CODE_W'(1) << (STEP_SHIFT * (NLEV - 1 - k));
    end
  end

  always_comb begin
    assert (!(in_lock_o && out_lock_o)) else $error("p_windows_disjoint_r6");
  end
endmodule

// File: rtl/fsc_code_reg.sv
module fsc_code_reg #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic [CODE_W-1:0] step_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W:0] sum;
  assign sum = {1'b0, code_o} + {1'b0, step_i};

  always_ff @(posedge clk) begin
    if (rst || clear_i)  code_o <= '0;
    else if (inc_i)      code_o <= sum[CODE_W] ? CODE_MAX : sum[CODE_W-1:0];
  end

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> code_o == '0);
  p_only_up_r4: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> code_o >= $past(code_o));
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (code_o == CODE_MAX && !clear_i) |=> code_o == CODE_MAX);
endmodule

// File: rtl/fsc_fsm.sv
module fsc_fsm
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lol_i,
  input  logic take_i,
  input  logic slow_i,
  input  logic in_lock_i,
  input  logic out_lock_i,
  output logic clear_o,
  output logic inc_o,
  output logic fine_en_o
);
  fsc_state_e state, state_nx;

  assign clear_o = lol_i || (state == ST_LOCKED && take_i && out_lock_i);
  assign inc_o   = !lol_i && state == ST_SEARCH && take_i && slow_i && !in_lock_i;

  always_comb begin
    state_nx = state;
    if (lol_i)                                      state_nx = ST_SEARCH;
    else if (take_i && state == ST_SEARCH && in_lock_i)  state_nx = ST_LOCKED;
    else if (take_i && state == ST_LOCKED && out_lock_i) state_nx = ST_SEARCH;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SEARCH;
    else     state <= state_nx;
  end

  assign fine_en_o = (state == ST_LOCKED);

  p_lol_drops_en_r2: assert property (@(posedge clk) disable iff (rst)
    lol_i |=> !fine_en_o);
  p_no_inc_locked_r7: assert property (@(posedge clk) disable iff (rst)
    fine_en_o |-> !inc_o);
endmodule

// File: rtl/freq_search_ctrl.sv
module freq_search_ctrl #(
  parameter int unsigned ERR_W      = 20,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned LOCK_PPM   = 250,
  parameter int unsigned UNLOCK_PPM = 1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lol,
  input  logic                    meas_valid,
  output logic                    meas_ready,
  input  logic signed [ERR_W-1:0] meas_err,
  output logic [CODE_W-1:0]       tune_code,
  output logic                    fine_en
);
  logic take, slow, in_lock, out_lock, clear, inc;
  logic [CODE_W-1:0] step;

  assign meas_ready = 1'b1;
  assign take       = meas_valid && meas_ready;

  fsc_err_classify #(
    .ERR_W(ERR_W), .CODE_W(CODE_W),
    .LOCK_PPM(LOCK_PPM), .UNLOCK_PPM(UNLOCK_PPM)
  ) u_classify (
    .err_i(meas_err), .slow_o(slow), .in_lock_o(in_lock),
    .out_lock_o(out_lock), .step_o(step)
  );

  fsc_fsm u_fsm (
    .clk(clk), .rst(rst), .lol_i(lol), .take_i(take), .slow_i(slow),
    .in_lock_i(in_lock), .out_lock_i(out_lock),
    .clear_o(clear), .inc_o(inc), .fine_en_o(fine_en)
  );

  fsc_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .clear_i(clear), .inc_i(inc),
    .step_i(step), .code_o(tune_code)
  );

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!meas_valid && !lol) |=> ($stable(tune_code) && $stable(fine_en)));
  p_locked_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (fine_en && !lol) |=> (tune_code == $past(tune_code) || tune_code == '0));
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(fine_en)) |-> tune_code == '0);
endmodule

// File: tb/freq_search_ctrl_bench.sv
module freq_search_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int ERR_W = 20;
  localparam int CODE_W = 12;
  localparam int CODE_MAX = 4095;
  localparam int PPM_PER_CODE = 50;

  logic clk = 0, rst = 1, lol = 0, meas_valid = 0;
  logic meas_ready;
  logic signed [ERR_W-1:0] meas_err = '0;
  logic [CODE_W-1:0] tune_code;
  logic fine_en;

  int errors = 0, checks = 0;
  int m_code = 0;
  bit m_lock = 0;
  bit comparing = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #(PERIOD/2) clk = ~clk;

  freq_search_ctrl u_freq_search_ctrl (
    .clk(clk), .rst(rst), .lol(lol), .meas_valid(meas_valid),
    .meas_ready(meas_ready), .meas_err(meas_err),
    .tune_code(tune_code), .fine_en(fine_en)
  );

  function automatic int step_of(int mag);
    if (mag >= 64000) return 256;
    if (mag >= 16000) return 64;
    if (mag >= 4000)  return 16;
    if (mag >= 1000)  return 4;
    return 1;
  endfunction

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    int e, mag;
    e = int'(meas_err);
    mag = (e < 0) ? -e : e;
    if (rst || lol) begin
      m_code = 0; m_lock = 0;
    end else if (meas_valid) begin
      if (!m_lock) begin
        if (mag <= 250) m_lock = 1;
        else if (e > 0) m_code = (m_code + step_of(mag) > CODE_MAX) ? CODE_MAX : m_code + step_of(mag);
      end else if (mag > 1000) begin
        m_code = 0; m_lock = 0;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && !finished) begin
      check(cur_req, int'(tune_code), m_code, "tune_code");
      check(cur_req, int'(fine_en), int'(m_lock), "fine_en");
      check("R3", int'(meas_ready), 1, "meas_ready");
    end
  end

  task automatic meas(int e);
    @(negedge clk);
    meas_valid = 1; meas_err = ERR_W'(e);
    @(negedge clk);
    meas_valid = 0; meas_err = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic close_loop(int target, int iters);
    for (int i = 0; i < iters; i++) begin
      @(negedge clk);
      meas_valid = 1;
      meas_err = ERR_W'((target - int'(tune_code)) * PPM_PER_CODE);
    end
    @(negedge clk);
    meas_valid = 0; meas_err = '0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    comparing = 1;
    idle(3);
    check("R1", int'(tune_code), 0, "reset code");
    check("R1", int'(fine_en), 0, "reset enable");
    @(negedge clk); rst = 0;

    cur_req = "R4";
    meas(64000); meas(63999); meas(16000); meas(15999);
    meas(4000); meas(3999); meas(1000); meas(999); meas(251);
    check("R4", int'(tune_code), 256+64+64+16+16+4+4+1+1, "step ladder total");

    cur_req = "R5";
    meas(-5000); meas(-251);
    cur_req = "R3";
    @(negedge clk); meas_err = ERR_W'(90000); idle(4);
    meas_err = '0;

    cur_req = "R6";
    meas(250);
    check("R6", int'(fine_en), 1, "lock at 250");
    cur_req = "R7";
    meas(1000); meas(-1000); meas(70000 - 69000);
    check("R7", int'(fine_en), 1, "hold at 1000");
    cur_req = "R8";
    meas(-1001);
    check("R8", int'(tune_code), 0, "release code");

    cur_req = "R2";
    meas(70000); meas(70000);
    @(negedge clk); lol = 1; meas_valid = 1; meas_err = ERR_W'(70000);
    @(negedge clk); lol = 0; meas_valid = 0;
    check("R2", int'(tune_code), 0, "lol clears");
    meas(-100);
    @(negedge clk); lol = 1;
    @(negedge clk); lol = 0;
    check("R2", int'(fine_en), 0, "lol drops enable");

    cur_req = "R6";
    close_loop(1733, 400);
    check("R6", int'(fine_en), 1, "closed loop lock");
    check("R6", (int'(tune_code) >= 1728 && int'(tune_code) <= 1738) ? 1 : 0, 1, "code near target");

    cur_req = "R9";
    @(negedge clk); lol = 1;
    @(negedge clk); lol = 0;
    close_loop(5000, 200);
    check("R9", int'(tune_code), CODE_MAX, "saturated code");
    check("R9", int'(fine_en), 0, "still searching");
    meas(64000);
    check("R9", int'(tune_code), CODE_MAX, "no wrap");

    idle(2);
    finish_run();
  end
endmodule